// File: doc/BRIEF.md
# Compact 10-bit PWM Timer

This block is a 10-bit up-counting timer with two match comparators and one output pin. The coarse comparator holds a 3-bit value that is weighed against the top three counter bits. A value of zero in it stands for the full 1024-count span. The fine comparator holds a full 10-bit value. The counter advances on a count tick. That tick comes from one of eight clock sources: the system clock, the system clock divided by four, a high-speed tick input divided by 16 or 64, a slow tick input, or either edge of a synchronised external clock pin.

Three operating modes share the counter. In compare-match mode, a fine match applies an action to the output level: keep, drive low, drive high or toggle. In PWM mode, one comparator sets the period and the other sets the duty, and a swap bit exchanges these two roles. In plain timer mode, the pin holds its initial level and only the match flags are live. A clear-select bit chooses which match restarts the counter outside PWM mode. Both match flags stay set until a write-one-to-clear strobe removes them.

A small state machine sequences the block. It has three states:
- STOP: the counter is held at zero and the output level is reloaded.
- RUN: the counter counts.
- HOLD: the counter is frozen.

The transitions are:
- STOP_TO_RUN: enable high, pause low.
- STOP_TO_HOLD: enable high, pause high.
- RUN_TO_HOLD: pause rises.
- HOLD_TO_RUN: pause falls.
- ANY_TO_STOP: enable low.

The state is registered. Counting therefore starts on the first tick after the clock edge that enters RUN.

Top module: `pwm_timer10`

## Requirements
- R1: After reset, both flags read 0. Once one clock edge has passed with `run` low, `pin` equals `init_lvl ^ pol`.
- R2: While the state is STOP (entered on the edge after `run` is low), the counter is held at 0. The internal output level is reloaded from `init_lvl`, so `pin` returns to `init_lvl ^ pol` one cycle after entering STOP.
- R3: In HOLD (`run`=1, `pause`=1) the counter does not change. Counting resumes from the held value in RUN.
- R4: `src_sel` encodings: 0 is every 4th clock, 1 is every clock, 2 is every 16th `fh_tick` pulse, 3 is every 64th `fh_tick` pulse, 4 and 5 are each `sub_tick` pulse, 6 is a rising edge and 7 is a falling edge of `ext_in`. `ext_in` passes through a 2-flop synchroniser before edge detection. The prescalers restart in STOP.
- R5: With P as the clear source, the counter runs from 0 to `per_val*128-1` and then wraps to 0, so the period is `per_val*128` ticks. A `per_val` of 0 gives 1024 ticks. `p_flag` sets on the tick that leaves the last count.
- R6: With `clr_sel`=1 (outside PWM mode), the counter clears on the tick that leaves the count equal to `a_val`, so the period is `a_val+1` ticks. `p_flag` is never set in this case.
- R7: In `mode`=00 (compare), the tick that leaves count `a_val` applies the action selected by `out_fn`: 00 keeps, 01 drives low, 10 drives high, 11 toggles.
- R8: In `mode`=10 (PWM) with `dpx`=0, the period is set by P as in R5. The raw level equals `init_lvl` (the active level) while count < `a_val`, and `~init_lvl` otherwise. `out_fn` and `clr_sel` are ignored.
- R9: In PWM mode with `dpx`=1, the period is `a_val+1` ticks. The raw level is active while count < `per_val*128`, and always active when `per_val`=0. `p_flag` is never set.
- R10: `pin` is the raw level XOR `pol` in every mode.
- R11: In `mode`=11 (timer) and in the undefined code 01, a match never changes `pin`. The counter and flags operate as in R5/R6.
- R12: `a_flag` and `p_flag` are sticky. `flag_clr[0]` clears `a_flag` and `flag_clr[1]` clears `p_flag`. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Run enable; low stops and zeroes the counter |
| pause | input | 1 | Freezes the counter while running |
| mode | input | 2 | 00 compare, 10 PWM, 11 timer, 01 undefined (as timer) |
| out_fn | input | 2 | Compare-match action: keep, low, high, toggle |
| init_lvl | input | 1 | Initial level; active level in PWM mode |
| pol | input | 1 | Inverts the pin |
| dpx | input | 1 | PWM role swap of the comparators |
| clr_sel | input | 1 | Clear source: 0 P match, 1 A match |
| src_sel | input | 3 | Count clock source select |
| fh_tick | input | 1 | High-speed tick enable input |
| sub_tick | input | 1 | Slow tick enable input |
| ext_in | input | 1 | Asynchronous external clock pin |
| per_val | input | 3 | Coarse (P) comparator value |
| a_val | input | 10 | Fine (A) comparator value |
| flag_clr | input | 2 | Write-one-to-clear strobe: bit0 A, bit1 P |
| pin | output | 1 | Output pin level |
| a_flag | output | 1 | Sticky A match flag |
| p_flag | output | 1 | Sticky P match flag |

## Verification
A behavioural reference model follows the block clock by clock and is compared on every cycle. The stimulus covers several compare runs with a short A-cleared period, one run for each output action. These runs separate toggle from set and clear, and show whether the action lands on the right tick. P-cleared runs with `per_val` of 1 and 0 separate the 128-count wrap from the full 1024 overflow. PWM runs in both swap settings and both polarities show which comparator drives the period and which drives the duty. Sweeps over all eight clock sources, with irregular tick and edge inputs, separate the dividers and the two edge senses. Pause, stop and flag-clear episodes show whether the counter freezes, whether it is zeroed, and that flags persist until cleared.

// File: rtl/tmr10_pkg.sv
package tmr10_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;

    typedef enum logic [1:0] {
        MD_CMP   = 2'b00,
        MD_UNDEF = 2'b01,
        MD_PWM   = 2'b10,
        MD_TMR   = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        OA_KEEP   = 2'b00,
        OA_LOW    = 2'b01,
        OA_HIGH   = 2'b10,
        OA_TOGGLE = 2'b11
    } out_act_e;

    typedef enum logic [2:0] {
        SRC_SYS_Q = 3'd0,
        SRC_SYS   = 3'd1,
        SRC_HI_A  = 3'd2,
        SRC_HI_B  = 3'd3,
        SRC_SUB   = 3'd4,
        SRC_SUB2  = 3'd5,
        SRC_EXT_R = 3'd6,
        SRC_EXT_F = 3'd7
    } clk_src_e;

endpackage

// File: rtl/tmr_tick_gen.sv
// Count-tick source: dividers restart while the timer is stopped (R4).
// Divider ratios must be powers of two.
module tmr_tick_gen
    import tmr10_pkg::*;
#(
    parameter int SYS_DIV  = 4,
    parameter int HI_DIV_A = 16,
    parameter int HI_DIV_B = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [2:0] src_sel,
    input  logic       fh_tick,
    input  logic       sub_tick,
    input  logic       ext_in,
    output logic       tick
);
    localparam int SYS_W = $clog2(SYS_DIV);
    localparam int HA_W  = $clog2(HI_DIV_A);
    localparam int HB_W  = $clog2(HI_DIV_B);

    logic [SYS_W-1:0] sys_q;
    logic [HB_W-1:0]  fh_q;
    logic [2:0]       ext_q;   // [0] first sync, [1] second sync, [2] previous
    logic             ext_rise, ext_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sys_q <= '0;
            fh_q  <= '0;
        end else if (restart) begin
            sys_q <= '0;
            fh_q  <= '0;
        end else begin
            sys_q <= sys_q + 1'b1;
            if (fh_tick) fh_q <= fh_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= '0;
        else        ext_q <= {ext_q[1:0], ext_in};
    end

    assign ext_rise = ext_q[1] & ~ext_q[2];
    assign ext_fall = ~ext_q[1] & ext_q[2];

    always_comb begin
        unique case (clk_src_e'(src_sel))
            SRC_SYS_Q:          tick = (sys_q == SYS_W'(SYS_DIV - 1));
            SRC_SYS:            tick = 1'b1;
            SRC_HI_A:           tick = fh_tick && (fh_q[HA_W-1:0] == {HA_W{1'b1}});
            SRC_HI_B:           tick = fh_tick && (fh_q == {HB_W{1'b1}});
            SRC_SUB, SRC_SUB2:  tick = sub_tick;
            SRC_EXT_R:          tick = ext_rise;
            SRC_EXT_F:          tick = ext_fall;
            default:            tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/tmr_cmp.sv
// Comparator pair: coarse P value against the top counter bits, fine A value.
module tmr_cmp #(
    parameter int CNT_W = 10,
    parameter int PER_W = 3
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [PER_W-1:0] per_val,
    input  logic [CNT_W-1:0] a_val,
    output logic             p_last,
    output logic             a_hit,
    output logic             p_duty,
    output logic             a_duty
);
    localparam int LOW_W = CNT_W - PER_W;

    logic [CNT_W-1:0] p_end;
    logic [CNT_W:0]   p_bound;

    // Zero P wraps to the all-ones count, i.e. plain overflow.
    assign p_end   = {per_val, {LOW_W{1'b0}}} - 1'b1;
    assign p_bound = (per_val == '0) ? {1'b1, {CNT_W{1'b0}}}
                                     : {1'b0, per_val, {LOW_W{1'b0}}};

    assign p_last = (cnt == p_end);
    assign a_hit  = (cnt == a_val);
    assign p_duty = ({1'b0, cnt} < p_bound);
    assign a_duty = (cnt < a_val);
endmodule

// File: rtl/pwm_timer10.sv
module pwm_timer10
    import tmr10_pkg::*;
#(
    parameter int CNT_W    = 10,
    parameter int PER_W    = 3,
    parameter int SYS_DIV  = 4,
    parameter int HI_DIV_A = 16,
    parameter int HI_DIV_B = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             pause,
    input  logic [1:0]       mode,
    input  logic [1:0]       out_fn,
    input  logic             init_lvl,
    input  logic             pol,
    input  logic             dpx,
    input  logic             clr_sel,
    input  logic [2:0]       src_sel,
    input  logic             fh_tick,
    input  logic             sub_tick,
    input  logic             ext_in,
    input  logic [PER_W-1:0] per_val,
    input  logic [CNT_W-1:0] a_val,
    input  logic [1:0]       flag_clr,
    output logic             pin,
    output logic             a_flag,
    output logic             p_flag
);
    localparam int LOW_W = CNT_W - PER_W;

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             out_q, a_flag_q, p_flag_q;
    logic             tick, step, clr_on_a, clr_now, is_pwm;
    logic             p_last, a_hit, p_duty, a_duty, duty_on;

    tmr_tick_gen #(
        .SYS_DIV (SYS_DIV),
        .HI_DIV_A(HI_DIV_A),
        .HI_DIV_B(HI_DIV_B)
    ) i_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q == ST_STOP),
        .src_sel (src_sel),
        .fh_tick (fh_tick),
        .sub_tick(sub_tick),
        .ext_in  (ext_in),
        .tick    (tick)
    );

    tmr_cmp #(.CNT_W(CNT_W), .PER_W(PER_W)) i_cmp (
        .cnt    (cnt_q),
        .per_val(per_val),
        .a_val  (a_val),
        .p_last (p_last),
        .a_hit  (a_hit),
        .p_duty (p_duty),
        .a_duty (a_duty)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (run) state_d = pause ? ST_HOLD : ST_RUN;   // STOP_TO_HOLD / STOP_TO_RUN
            ST_RUN:  if (!run) state_d = ST_STOP;                   // ANY_TO_STOP
                     else if (pause) state_d = ST_HOLD;             // RUN_TO_HOLD
            ST_HOLD: if (!run) state_d = ST_STOP;                   // ANY_TO_STOP
                     else if (!pause) state_d = ST_RUN;             // HOLD_TO_RUN
            default: state_d = ST_STOP;
        endcase
    end

    // ---------------- outputs of the state machine ----------------
    assign is_pwm   = (tmr_mode_e'(mode) == MD_PWM);
    assign clr_on_a = is_pwm ? dpx : clr_sel;
    assign clr_now  = clr_on_a ? a_hit : p_last;
    assign step     = (state_q == ST_RUN) && tick;
    assign duty_on  = dpx ? p_duty : a_duty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_STOP: begin
                    cnt_q <= '0;
                    out_q <= init_lvl;
                end
                ST_RUN: if (tick) begin
                    cnt_q <= clr_now ? '0 : cnt_q + 1'b1;
                    if (a_hit && tmr_mode_e'(mode) == MD_CMP) begin
                        unique case (out_act_e'(out_fn))
                            OA_KEEP:   out_q <= out_q;
                            OA_LOW:    out_q <= 1'b0;
                            OA_HIGH:   out_q <= 1'b1;
                            OA_TOGGLE: out_q <= ~out_q;
                        endcase
                    end
                end
                ST_HOLD: cnt_q <= cnt_q;
                default: cnt_q <= '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_flag_q <= 1'b0;
            p_flag_q <= 1'b0;
        end else begin
            if (step && a_hit)                 a_flag_q <= 1'b1;
            else if (flag_clr[0])              a_flag_q <= 1'b0;
            if (step && p_last && !clr_on_a)   p_flag_q <= 1'b1;
            else if (flag_clr[1])              p_flag_q <= 1'b0;
        end
    end

    assign pin    = ((is_pwm && state_q != ST_STOP) ? (duty_on ? init_lvl : ~init_lvl) : out_q) ^ pol;
    assign a_flag = a_flag_q;
    assign p_flag = p_flag_q;

    // ---------------- assertions ----------------
    AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |=> (cnt_q == '0));                                      // R2
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> $stable(cnt_q));                                     // R3
    AST_PERIOD_END: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clr_on_a && cnt_q == {per_val, {LOW_W{1'b0}}} - 1'b1) |=> (cnt_q == '0)); // R5
    AST_NO_P_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        (step && clr_on_a) |=> !$rose(p_flag_q));                                     // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_flag_q && !flag_clr[0]) |=> a_flag_q);                                     // R12
endmodule

// File: tb/test_pwm_timer10.sv
module test_pwm_timer10;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 0, pause = 0, init_lvl = 1, pol = 0, dpx = 0, clr_sel = 0;
    logic [1:0] mode = 0, out_fn = 0, flag_clr = 0;
    logic [2:0] src_sel = 1, per_val = 0;
    logic [9:0] a_val = 0;
    logic       fh_tick = 0, sub_tick = 0, ext_in = 0;
    logic       pin, a_flag, p_flag;

    int    total = 0, bad = 0, cyc = 0;
    bit    done = 0;
    string cur_req = "R1";

    // reference model state
    int m_state = 0;   // 0 stop, 1 run, 2 hold
    int m_cnt = 0, m_sys = 0, m_fh = 0;
    bit m_out = 0, m_af = 0, m_pf = 0, m_s1 = 0, m_s2 = 0, m_pv = 0;

    pwm_timer10 i_pwm_timer10 (
        .clk(clk), .rst_n(rst_n), .run(run), .pause(pause), .mode(mode),
        .out_fn(out_fn), .init_lvl(init_lvl), .pol(pol), .dpx(dpx),
        .clr_sel(clr_sel), .src_sel(src_sel), .fh_tick(fh_tick),
        .sub_tick(sub_tick), .ext_in(ext_in), .per_val(per_val),
        .a_val(a_val), .flag_clr(flag_clr), .pin(pin), .a_flag(a_flag),
        .p_flag(p_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    function automatic bit model_pin();
        bit duty, raw;
        int bound;
        bound = (per_val == 0) ? 1024 : int'(per_val) * 128;
        duty  = dpx ? (m_cnt < bound) : (m_cnt < int'(a_val));
        if (mode == 2'b10 && m_state != 0) raw = duty ? init_lvl : ~init_lvl;
        else                               raw = m_out;
        return raw ^ pol;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin : mdl
        bit tk, is_pwm, clra, ah, pl, stp;
        int pend;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_sys = 0; m_fh = 0;
            m_out = 0; m_af = 0; m_pf = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
        end else begin
            case (src_sel)
                3'd0: tk = (m_sys == 3);
                3'd1: tk = 1;
                3'd2: tk = fh_tick && (m_fh % 16 == 15);
                3'd3: tk = fh_tick && (m_fh == 63);
                3'd4, 3'd5: tk = sub_tick;
                3'd6: tk = m_s2 && !m_pv;
                default: tk = !m_s2 && m_pv;
            endcase
            if (m_state == 0) begin m_sys = 0; m_fh = 0; end
            else begin
                m_sys = (m_sys + 1) % 4;
                if (fh_tick) m_fh = (m_fh + 1) % 64;
            end
            m_pv = m_s2; m_s2 = m_s1; m_s1 = ext_in;

            is_pwm = (mode == 2'b10);
            clra   = is_pwm ? dpx : clr_sel;
            pend   = (per_val == 0) ? 1023 : int'(per_val) * 128 - 1;
            ah     = (m_cnt == int'(a_val));
            pl     = (m_cnt == pend);
            stp    = (m_state == 1) && tk;

            if (flag_clr[0]) m_af = 0;
            if (flag_clr[1]) m_pf = 0;
            if (stp && ah) m_af = 1;
            if (stp && pl && !clra) m_pf = 1;

            if (m_state == 0) begin
                m_cnt = 0; m_out = init_lvl;
            end else if (stp) begin
                if (mode == 2'b00 && ah) begin
                    case (out_fn)
                        2'b01: m_out = 0;
                        2'b10: m_out = 1;
                        2'b11: m_out = ~m_out;
                        default: m_out = m_out;
                    endcase
                end
                m_cnt = (clra ? ah : pl) ? 0 : (m_cnt + 1) % 1024;
            end
            m_state = !run ? 0 : (pause ? 2 : 1);
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "pin",    pin,    model_pin());
            chk(cur_req, "a_flag", a_flag, m_af);
            chk(cur_req, "p_flag", p_flag, m_pf);
        end
    end

    // irregular tick and external clock patterns
    always @(posedge clk) begin
        #2;
        cyc++;
        fh_tick  = (cyc % 3 == 0);
        sub_tick = (cyc % 5 == 0) || (cyc % 11 == 0);
        ext_in   = ((cyc / 7) % 2 == 1) ^ ((cyc % 13) == 0);
    end

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic clear_flags();
        wait_cyc(1); flag_clr = 2'b11;
        wait_cyc(1); flag_clr = 2'b00;
    endtask

    task automatic stop_run(int idle);
        run = 0; wait_cyc(idle); run = 1;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        @(negedge clk);
        chk("R1", "reset pin", pin, 1'b1);
        chk("R1", "reset a_flag", a_flag, 1'b0);
        chk("R1", "reset p_flag", p_flag, 1'b0);

        // compare-match actions, A-cleared short period
        cur_req = "R7"; mode = 2'b00; clr_sel = 1; a_val = 5; src_sel = 1;
        out_fn = 2'b11; run = 1; wait_cyc(40);
        out_fn = 2'b01; wait_cyc(20);
        out_fn = 2'b10; wait_cyc(20);
        out_fn = 2'b00; wait_cyc(20);
        out_fn = 2'b11; wait_cyc(20);

        // P-cleared periods: 128 then full 1024
        cur_req = "R5"; clr_sel = 0; per_val = 1; a_val = 100;
        stop_run(2); wait_cyc(300);
        cur_req = "R12"; clear_flags(); wait_cyc(150);
        cur_req = "R5"; per_val = 0; stop_run(2); wait_cyc(1100);

        // A-cleared: no P flag
        cur_req = "R6"; run = 0; clear_flags(); clr_sel = 1; a_val = 20;
        run = 1; wait_cyc(200);
        @(negedge clk);
        chk("R6", "p_flag stays clear", p_flag, 1'b0);
        chk("R6", "a_flag set", a_flag, 1'b1);

        // every clock source
        cur_req = "R4"; a_val = 3; out_fn = 2'b11;
        for (int s = 0; s < 8; s++) begin
            src_sel = 3'(s); stop_run(2);
            wait_cyc((s == 3) ? 1000 : 300);
        end
        src_sel = 1;

        // PWM, P period, A duty
        cur_req = "R8"; mode = 2'b10; dpx = 0; per_val = 1; a_val = 40; out_fn = 2'b00;
        clr_sel = 1; stop_run(2); wait_cyc(400);
        cur_req = "R10"; pol = 1; wait_cyc(200);
        cur_req = "R8"; init_lvl = 0; wait_cyc(200); init_lvl = 1; pol = 0;

        // PWM, swapped roles
        cur_req = "R9"; run = 0; clear_flags(); dpx = 1; a_val = 300; per_val = 1;
        run = 1; wait_cyc(700);
        per_val = 0; wait_cyc(400);
        @(negedge clk);
        chk("R9", "no p_flag with swap", p_flag, 1'b0);

        // pause freezes the count
        cur_req = "R3"; dpx = 0; per_val = 1; a_val = 64; stop_run(2);
        wait_cyc(50); pause = 1; wait_cyc(30); pause = 0; wait_cyc(100);
        pause = 1; stop_run(1); wait_cyc(10); pause = 0; wait_cyc(50);

        // stop returns the pin to its initial level
        cur_req = "R2"; mode = 2'b00; out_fn = 2'b11; clr_sel = 1; a_val = 2;
        wait_cyc(10); run = 0; wait_cyc(3);
        @(negedge clk);
        chk("R2", "pin after stop", pin, 1'b1);
        run = 1; wait_cyc(30);

        // timer and undefined modes: pin holds, flags live
        cur_req = "R11"; run = 0; clear_flags(); mode = 2'b11; out_fn = 2'b11;
        run = 1; wait_cyc(100);
        @(negedge clk);
        chk("R11", "timer pin holds", pin, 1'b1);
        chk("R11", "timer a_flag", a_flag, 1'b1);
        mode = 2'b01; out_fn = 2'b01; wait_cyc(100);
        @(negedge clk);
        chk("R11", "undefined-mode pin holds", pin, 1'b1);

        // flag clear while stopped
        cur_req = "R12"; run = 0; wait_cyc(2); clear_flags(); wait_cyc(1);
        @(negedge clk);
        chk("R12", "a_flag cleared", a_flag, 1'b0);
        chk("R12", "p_flag cleared", p_flag, 1'b0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule